// File: doc/BRIEF.md
# Effective Address Offset Unit

This block takes a decoded memory-operand descriptor and produces the operand's offset: an optional base value, plus an optional index value scaled by 1, 2, 4 or 8, plus a signed displacement. The result goes to a general-purpose destination register. The block never reads or writes memory. It only delivers the value together with a write strobe.

Two size selects control the final value. The address-size select sets the width at which the sum wraps, either 16 or 32 bits. The operand-size select sets how much of the result is written. Any combination that involves a 16-bit size delivers only the low 16 bits, with the upper bits cleared. A descriptor flagged as a register-form source is illegal: the block raises an invalid-opcode flag and withholds the write.

The outputs are registered and appear exactly one cycle after an accepted input, marked by a one-cycle valid pulse. Because the index may be the same register as the base, an execute stage can use the unit to multiply a value by 3, 5 or 9.

Top module: `ea_offset_unit`

## Requirements
- R1: With 32-bit address size and 32-bit operand size, `result` equals base + (index << scale) + displacement, taken modulo 2^32, and `wr_en` is 1.
- R2: The 2-bit `scale` code selects the index multiplier: 0 gives x1, 1 gives x2, 2 gives x4 and 3 gives x8.
- R3: A base whose `base_present` is 0, or an index whose `index_present` is 0, adds zero whatever its value.
- R4: With 16-bit address size and 16-bit operand size, `result[15:0]` is the sum modulo 2^16, including negative displacements, and `result[31:16]` is 0.
- R5: With 32-bit address size and 16-bit operand size, `result[15:0]` is the low 16 bits of the 32-bit sum, and `result[31:16]` is 0.
- R6: With 16-bit address size and 32-bit operand size, the 16-bit sum is zero-extended to 32 bits. A carry out of bit 15 is discarded.
- R7: When `src_is_reg` is 1, the output cycle shows `ud_fault` = 1, `wr_en` = 0 and `result` = 0.
- R8: `out_valid` is 1 exactly in the cycle after each cycle with `in_valid` = 1. `wr_en` and `ud_fault` are never 1 together, and neither is 1 without `out_valid`.
- R9: While `rst_n` is 0, and after it is released, `out_valid`, `wr_en`, `ud_fault` and `result` are all 0 until an input is accepted.
- R10: With base and index set to the same value v, both present, scale codes 1, 2 and 3 give 3v, 5v and 9v.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Descriptor valid this cycle |
| base_val | input | 32 | Base register value |
| base_present | input | 1 | Base component used |
| index_val | input | 32 | Index register value |
| index_present | input | 1 | Index component used |
| scale | input | 2 | Index scale code |
| disp | input | 32 | Signed displacement |
| src_is_reg | input | 1 | Source is register form (illegal) |
| addr_wide | input | 1 | 1 = 32-bit address size, 0 = 16-bit |
| op_wide | input | 1 | 1 = 32-bit operand size, 0 = 16-bit |
| out_valid | output | 1 | Result cycle marker |
| result | output | 32 | Value for the destination register |
| wr_en | output | 1 | Destination write strobe |
| ud_fault | output | 1 | Invalid-opcode indication |

## Verification
Wrapping of the 16-bit sum and zero-extension to the 32-bit operand can occur in the same cycle. The bench provokes this with a 16-bit-address, 32-bit-operand descriptor whose low-half sum carries out of bit 15. The result passes only if the carry is discarded and bit 16 stays clear. A second overlap is a fault in one cycle followed directly by a legal write in the next. That pair is driven back to back, and the bench checks that the fault output clears and the write strobe rises with the next cycle's value.

// File: rtl/ea_pkg.sv
package ea_pkg;
   typedef enum logic [1:0] {
      SC_X1 = 2'd0,
      SC_X2 = 2'd1,
      SC_X4 = 2'd2,
      SC_X8 = 2'd3
   } scale_e;
endpackage

// File: rtl/ea_index_scaler.sv
module ea_index_scaler #(
   parameter int W       = 32,
   parameter int SCALE_W = 2
) (
   input  logic [W-1:0]       idx,
   input  logic               present,
   input  logic [SCALE_W-1:0] scale,
   output logic [W-1:0]       term
);
   localparam int MAX_SHIFT = (1 << SCALE_W) - 1;

   generate
      if (MAX_SHIFT >= W) begin : g_bad
         $error("scale range exceeds index width");
      end
   endgenerate

   always_comb begin
      term = present ? (idx << scale) : '0;
   end
endmodule

// File: rtl/ea_offset_adder.sv
module ea_offset_adder #(
   parameter int WIDE_W   = 32,
   parameter int NARROW_W = 16,
   parameter int DISP_W   = 32
) (
   input  logic [WIDE_W-1:0] base,
   input  logic              base_present,
   input  logic [WIDE_W-1:0] idx_term,
   input  logic [DISP_W-1:0] disp,
   input  logic              addr_wide,
   output logic [WIDE_W-1:0] sum
);
   localparam logic [WIDE_W-1:0] NARROW_MASK =
      {{(WIDE_W-NARROW_W){1'b0}}, {NARROW_W{1'b1}}};

   logic [WIDE_W-1:0] disp_ext;
   logic [WIDE_W-1:0] raw;

   generate
      if (DISP_W > WIDE_W) begin : g_bad
         $error("displacement wider than address");
      end else if (DISP_W < WIDE_W) begin : g_sext
         assign disp_ext = {{(WIDE_W-DISP_W){disp[DISP_W-1]}}, disp};
      end else begin : g_same
         assign disp_ext = disp;
      end
   endgenerate

   always_comb begin
      raw = (base_present ? base : '0) + idx_term + disp_ext;
      sum = addr_wide ? raw : (raw & NARROW_MASK);
   end
endmodule

// File: rtl/ea_result_fit.sv
module ea_result_fit #(
   parameter int WIDE_W   = 32,
   parameter int NARROW_W = 16
) (
   input  logic [WIDE_W-1:0] sum,
   input  logic              op_wide,
   output logic [WIDE_W-1:0] fitted
);
   always_comb begin
      fitted = '0;
      if (op_wide) fitted = sum;
      else         fitted[NARROW_W-1:0] = sum[NARROW_W-1:0];
   end
endmodule

// File: rtl/ea_offset_unit.sv
module ea_offset_unit #(
   parameter int WIDE_W   = 32,
   parameter int NARROW_W = 16,
   parameter int DISP_W   = 32,
   parameter int SCALE_W  = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               in_valid,
   input  logic [WIDE_W-1:0]  base_val,
   input  logic               base_present,
   input  logic [WIDE_W-1:0]  index_val,
   input  logic               index_present,
   input  logic [SCALE_W-1:0] scale,
   input  logic [DISP_W-1:0]  disp,
   input  logic               src_is_reg,
   input  logic               addr_wide,
   input  logic               op_wide,
   output logic               out_valid,
   output logic [WIDE_W-1:0]  result,
   output logic               wr_en,
   output logic               ud_fault
);
   generate
      if (NARROW_W >= WIDE_W) begin : g_bad_w
         $error("narrow width must be below wide width");
      end
      if (NARROW_W < 1) begin : g_bad_n
         $error("narrow width must be positive");
      end
   endgenerate

   logic [WIDE_W-1:0] idx_term;
   logic [WIDE_W-1:0] sum;
   logic [WIDE_W-1:0] fitted;

   ea_index_scaler #(.W(WIDE_W), .SCALE_W(SCALE_W)) i_scaler (
      .idx(index_val), .present(index_present), .scale(scale), .term(idx_term)
   );

   ea_offset_adder #(.WIDE_W(WIDE_W), .NARROW_W(NARROW_W), .DISP_W(DISP_W)) i_adder (
      .base(base_val), .base_present(base_present), .idx_term(idx_term),
      .disp(disp), .addr_wide(addr_wide), .sum(sum)
   );

   ea_result_fit #(.WIDE_W(WIDE_W), .NARROW_W(NARROW_W)) i_fit (
      .sum(sum), .op_wide(op_wide), .fitted(fitted)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         wr_en     <= 1'b0;
         ud_fault  <= 1'b0;
         result    <= '0;
      end else begin
         out_valid <= in_valid;
         wr_en     <= in_valid && !src_is_reg;
         ud_fault  <= in_valid && src_is_reg;
         result    <= (in_valid && !src_is_reg) ? fitted : '0;
      end
   end

   // R8
   latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);
   // R8
   strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en || ud_fault) |-> (out_valid && !(wr_en && ud_fault)));
   // R7
   reg_form_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && src_is_reg) |=> (ud_fault && !wr_en && result == '0));
   // R4
   narrow_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !(addr_wide && op_wide)) |=> (result[WIDE_W-1:NARROW_W] == '0));
   // R9
   idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> (!out_valid && !wr_en && !ud_fault));
endmodule

// File: tb/test_ea_offset_unit.sv
module test_ea_offset_unit;
   logic        clk = 1'b0;
   logic        rst_n;
   logic        in_valid;
   logic [31:0] base_val;
   logic        base_present;
   logic [31:0] index_val;
   logic        index_present;
   logic [1:0]  scale;
   logic [31:0] disp;
   logic        src_is_reg;
   logic        addr_wide;
   logic        op_wide;
   logic        out_valid;
   logic [31:0] result;
   logic        wr_en;
   logic        ud_fault;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   ea_offset_unit i_ea_offset_unit (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
      .base_val(base_val), .base_present(base_present),
      .index_val(index_val), .index_present(index_present),
      .scale(scale), .disp(disp), .src_is_reg(src_is_reg),
      .addr_wide(addr_wide), .op_wide(op_wide),
      .out_valid(out_valid), .result(result), .wr_en(wr_en), .ud_fault(ud_fault)
   );

   typedef struct packed {
      logic [31:0] b;
      logic        bp;
      logic [31:0] x;
      logic        xp;
      logic [1:0]  sc;
      logic [31:0] d;
      logic        rg;
      logic        aw;
      logic        ow;
      logic [31:0] exp;
      logic        ewr;
      logic        eud;
      logic [7:0]  req;
   } vec_t;

   localparam int NV = 12;
   localparam vec_t VECS [NV] = '{
      // R2 x4 scale, R1 full width
      '{32'h1000, 1'b1, 32'h20, 1'b1, 2'd2, 32'h8, 1'b0, 1'b1, 1'b1, 32'h1088, 1'b1, 1'b0, 8'd2},
      // R1 negative displacement, x8
      '{32'h12345678, 1'b1, 32'h10, 1'b1, 2'd3, 32'hFFFFFFFC, 1'b0, 1'b1, 1'b1, 32'h123456F4, 1'b1, 1'b0, 8'd1},
      // R3 absent base
      '{32'hDEADBEEF, 1'b0, 32'h7, 1'b1, 2'd0, 32'h100, 1'b0, 1'b1, 1'b1, 32'h107, 1'b1, 1'b0, 8'd3},
      // R3 absent index
      '{32'h40, 1'b1, 32'hFFFFFFFF, 1'b0, 2'd3, 32'h0, 1'b0, 1'b1, 1'b1, 32'h40, 1'b1, 1'b0, 8'd3},
      // R4 16/16 wrap
      '{32'h0000FFF0, 1'b1, 32'h20, 1'b1, 2'd0, 32'h0, 1'b0, 1'b0, 1'b0, 32'h10, 1'b1, 1'b0, 8'd4},
      // R5 op16 addr32 truncation
      '{32'h0012F000, 1'b1, 32'h1000, 1'b1, 2'd0, 32'h34, 1'b0, 1'b1, 1'b0, 32'h34, 1'b1, 1'b0, 8'd5},
      // R6 op32 addr16 zero-extend with carry out of bit 15
      '{32'h0001FFFF, 1'b1, 32'h1, 1'b1, 2'd1, 32'h0, 1'b0, 1'b0, 1'b1, 32'h1, 1'b1, 1'b0, 8'd6},
      // R7 register-form source
      '{32'h100, 1'b1, 32'h4, 1'b1, 2'd1, 32'h10, 1'b1, 1'b1, 1'b1, 32'h0, 1'b0, 1'b1, 8'd7},
      // R10 x3
      '{32'h111, 1'b1, 32'h111, 1'b1, 2'd1, 32'h0, 1'b0, 1'b1, 1'b1, 32'h333, 1'b1, 1'b0, 8'd10},
      // R10 x5
      '{32'h111, 1'b1, 32'h111, 1'b1, 2'd2, 32'h0, 1'b0, 1'b1, 1'b1, 32'h555, 1'b1, 1'b0, 8'd10},
      // R10 x9
      '{32'h111, 1'b1, 32'h111, 1'b1, 2'd3, 32'h0, 1'b0, 1'b1, 1'b1, 32'h999, 1'b1, 1'b0, 8'd10},
      // R4 negative displacement below zero
      '{32'h2, 1'b1, 32'h0, 1'b0, 2'd0, 32'hFFFFFFFD, 1'b0, 1'b0, 1'b0, 32'hFFFF, 1'b1, 1'b0, 8'd4}
   };

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic drive(input vec_t v);
      base_val = v.b; base_present = v.bp; index_val = v.x; index_present = v.xp;
      scale = v.sc; disp = v.d; src_is_reg = v.rg; addr_wide = v.aw; op_wide = v.ow;
   endtask

   task automatic check_out(input vec_t v);
      string t;
      t = $sformatf("R%0d", v.req);
      check({t, " out_valid"}, {31'b0, out_valid}, 32'd1);
      check({t, " result"}, result, v.exp);
      check({t, " wr_en"}, {31'b0, wr_en}, {31'b0, v.ewr});
      check({t, " ud_fault"}, {31'b0, ud_fault}, {31'b0, v.eud});
   endtask

   initial begin
      for (int i = 0; i < 20000; i++) @(posedge clk);
      if (!done) begin
         failures++;
         $display("FAIL watchdog expired");
         $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      rst_n = 1'b0; in_valid = 1'b0;
      drive(VECS[0]);
      repeat (3) @(negedge clk);
      // R9 outputs during reset
      check("R9 out_valid in reset", {31'b0, out_valid}, 32'd0);
      check("R9 result in reset", result, 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R9 wr_en after reset", {31'b0, wr_en}, 32'd0);
      check("R9 ud_fault after reset", {31'b0, ud_fault}, 32'd0);

      for (int i = 0; i < NV; i++) begin
         drive(VECS[i]);
         in_valid = 1'b1;
         @(negedge clk);
         in_valid = 1'b0;
         check_out(VECS[i]);
         @(negedge clk);
         // R8 single-cycle pulse
         check("R8 out_valid drops", {31'b0, out_valid}, 32'd0);
      end

      // R7 R8 back to back: fault then legal write
      drive(VECS[7]); in_valid = 1'b1;
      @(negedge clk);
      check_out(VECS[7]);
      drive(VECS[8]);
      @(negedge clk);
      in_valid = 1'b0;
      check_out(VECS[8]);
      check("R7 fault clears next cycle", {31'b0, ud_fault}, 32'd0);
      @(negedge clk);
      check("R8 idle wr_en", {31'b0, wr_en}, 32'd0);

      // R9 reset mid-stream clears outputs
      drive(VECS[0]); in_valid = 1'b1;
      @(negedge clk);
      rst_n = 1'b0; in_valid = 1'b0;
      @(negedge clk);
      check("R9 result cleared", result, 32'd0);
      check("R9 out_valid cleared", {31'b0, out_valid}, 32'd0);
      rst_n = 1'b1;
      @(negedge clk);

      done = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule